// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides an unsigned dividend by an unsigned divisor of the same width and yields one quotient bit per iteration. It uses the restoring method. A partial remainder one bit wider than the operands starts at zero. The dividend sits in a quotient shift register. On each iteration the block shifts the remainder and quotient pair left by one bit and subtracts the divisor. If the trial result goes negative, the block adds the divisor back and clears the new quotient bit. Otherwise it keeps the result and sets the bit.

A caller presents both operands and pulses `start_i` while the block is idle. A fixed number of cycles later `done_o` pulses for one cycle. The quotient and remainder are then valid, and they stay held until the next accepted start. A zero divisor is caught when the start is accepted. The iterations are skipped, a flag is raised and a saturated quotient is returned.

Top module: `restoring_divider`

## Requirements
- R1: While reset is asserted and after its release, `quotient_o` and `remainder_o` are zero, and `done_o` and `div_zero_o` are low.
- R2: For a nonzero divisor, `quotient_o` equals the integer part of dividend divided by divisor while `done_o` is high.
- R3: For a nonzero divisor, `remainder_o` equals dividend modulo divisor, and is therefore below the divisor, while `done_o` is high.
- R4: For a nonzero divisor, `done_o` is high for exactly one cycle. That cycle follows the 2*WIDTH-th rising edge after the edge that samples the start.
- R5: For a zero divisor, `div_zero_o` goes high, `quotient_o` is all ones, `remainder_o` equals the dividend, and `done_o` is high in the cycle right after the edge that samples the start.
- R6: `div_zero_o` keeps its value until the next accepted start. A start with a nonzero divisor clears it from the cycle after that start onward.
- R7: A start is accepted only while idle. A start that arrives during any iteration, or in the done cycle, changes neither the result nor the timing of the running division, and it launches no new division.
- R8: After `done_o`, `quotient_o` and `remainder_o` stay unchanged while the block is idle and no start arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch strobe, sampled only when idle |
| dividend_i | input | WIDTH | Unsigned dividend, sampled with the start |
| divisor_i | input | WIDTH | Unsigned divisor, sampled with the start |
| quotient_o | output | WIDTH | Quotient, all ones after a zero divisor |
| remainder_o | output | WIDTH | Remainder, the dividend after a zero divisor |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| div_zero_o | output | 1 | Divide-by-zero flag for the last accepted start |

## Verification
For a nonzero divisor the result is due 2*WIDTH rising edges after the edge that samples the start: one shift/subtract cycle and one restore/decide cycle per bit. For a zero divisor it is due in the cycle right after that edge. The bench drives and samples on falling edges and counts falling edges from the start until `done_o` rises. It requires that exact count, reads the quotient, remainder and flag in that same cycle, and then requires `done_o` low one cycle later. Ignored starts are injected partway through an iteration and during the done cycle. The bench then checks that the count and the result belong to the first operands and that the held outputs do not move.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_SHIFT_SUB = 2'd1,
    ST_RESTORE   = 2'd2,
    ST_DONE      = 2'd3
  } div_state_e;
endpackage

// File: rtl/div_addsub.sv
// Ripple add/subtract: sum = a + b, or a - b when sub_i is set.
module div_addsub #(
  parameter int N = 5
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         sub_i,
  output logic [N-1:0] sum_o
);
  logic [N-1:0] bx;
  logic [N-1:0] c;

  assign bx   = b_i ^ {N{sub_i}};
  assign c[0] = sub_i;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign sum_o[i] = a_i[i] ^ bx[i] ^ c[i];
    if (i < N - 1) begin : g_carry
      assign c[i+1] = (a_i[i] & bx[i]) | (c[i] & (a_i[i] ^ bx[i]));
    end
  end
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       divisor_zero_i,
  output div_state_e state_o,
  output logic       load_o,
  output logic       load_zero_o,
  output logic       shift_sub_o,
  output logic       restore_o,
  output logic       done_o,
  output logic       div_zero_o
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  div_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             dz_q;
  logic             accept;

  assign accept = start_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (accept) state_d = divisor_zero_i ? ST_DONE : ST_SHIFT_SUB;
      ST_SHIFT_SUB: state_d = ST_RESTORE;
      ST_RESTORE:   state_d = (cnt_q == LAST) ? ST_DONE : ST_SHIFT_SUB;
      ST_DONE:      state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      dz_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        cnt_q <= '0;
        dz_q  <= divisor_zero_i;
      end else if (state_q == ST_RESTORE) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign state_o     = state_q;
  assign load_o      = accept && !divisor_zero_i;
  assign load_zero_o = accept && divisor_zero_i;
  assign shift_sub_o = (state_q == ST_SHIFT_SUB);
  assign restore_o   = (state_q == ST_RESTORE);
  assign done_o      = (state_q == ST_DONE);
  assign div_zero_o  = dz_q;
endmodule

// File: rtl/div_datapath.sv
module div_datapath #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  input  logic             load_i,
  input  logic             load_zero_i,
  input  logic             shift_sub_i,
  input  logic             restore_i,
  output logic [WIDTH-1:0] quotient_o,
  output logic [WIDTH-1:0] remainder_o
);
  localparam int AW = WIDTH + 1;

  logic [AW-1:0]    rem_q;
  logic [WIDTH-1:0] quo_q;
  logic [WIDTH-1:0] dvs_q;
  logic [AW-1:0]    shifted;
  logic [AW-1:0]    op_a;
  logic [AW-1:0]    sum;

  assign shifted = {rem_q[WIDTH-1:0], quo_q[WIDTH-1]};
  assign op_a    = shift_sub_i ? shifted : rem_q;

  // One shared adder: subtract during shift, add back during restore.
  div_addsub #(.N(AW)) i_addsub (
    .a_i   (op_a),
    .b_i   ({1'b0, dvs_q}),
    .sub_i (shift_sub_i),
    .sum_o (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load_i) begin
      rem_q <= '0;
      quo_q <= dividend_i;
      dvs_q <= divisor_i;
    end else if (load_zero_i) begin
      rem_q <= {1'b0, dividend_i};
      quo_q <= '1;
      dvs_q <= divisor_i;
    end else if (shift_sub_i) begin
      rem_q <= sum;
      quo_q <= quo_q << 1;
    end else if (restore_i) begin
      if (rem_q[AW-1]) begin
        rem_q    <= sum;
        quo_q[0] <= 1'b0;
      end else begin
        quo_q[0] <= 1'b1;
      end
    end
  end

  assign quotient_o  = quo_q;
  assign remainder_o = rem_q[WIDTH-1:0];
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider
  import div_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic [WIDTH-1:0] quotient_o,
  output logic [WIDTH-1:0] remainder_o,
  output logic             done_o,
  output logic             div_zero_o
);
  div_state_e state;
  logic       load, load_zero, shift_sub, restore;

  div_ctrl #(.WIDTH(WIDTH)) i_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .divisor_zero_i (divisor_i == '0),
    .state_o        (state),
    .load_o         (load),
    .load_zero_o    (load_zero),
    .shift_sub_o    (shift_sub),
    .restore_o      (restore),
    .done_o         (done_o),
    .div_zero_o     (div_zero_o)
  );

  div_datapath #(.WIDTH(WIDTH)) i_datapath (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dividend_i  (dividend_i),
    .divisor_i   (divisor_i),
    .load_i      (load),
    .load_zero_i (load_zero),
    .shift_sub_i (shift_sub),
    .restore_i   (restore),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o)
  );
endmodule

// File: rtl/div_checker.sv
module div_checker
  import div_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [WIDTH-1:0] dividend_i,
  input logic [WIDTH-1:0] divisor_i,
  input div_state_e       state_i,
  input logic             done_i,
  input logic             div_zero_i,
  input logic [WIDTH-1:0] quotient_i,
  input logic [WIDTH-1:0] remainder_i
);
  localparam int P = 2 * WIDTH;

  logic             accept;
  logic [15:0]      cyc_q;
  logic [WIDTH-1:0] dvd_q, dvs_q;

  assign accept = start_i && (state_i == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      dvd_q <= '0;
      dvs_q <= '0;
    end else if (accept) begin
      cyc_q <= '0;
      dvd_q <= dividend_i;
      dvs_q <= divisor_i;
    end else if (cyc_q != 16'hFFFF) begin
      cyc_q <= cyc_q + 16'd1;
    end
  end

  p_quotient_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !div_zero_i |->
      P'(quotient_i) * P'(dvs_q) + P'(remainder_i) == P'(dvd_q));

  p_rem_below_divisor_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !div_zero_i |-> remainder_i < dvs_q);

  p_done_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R4, R5, R7: latency measured from the accepted start only
  p_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (div_zero_i ? (cyc_q == 16'd0) : (cyc_q == 16'(P))));

  p_zero_result_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && div_zero_i |-> (quotient_i == '1) && (remainder_i == dvd_q));

  p_flag_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && (divisor_i != '0) |=> !div_zero_i);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) && !start_i |=> $stable(quotient_i) && $stable(remainder_i));
endmodule

bind restoring_divider div_checker #(.WIDTH(WIDTH)) i_div_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .dividend_i  (dividend_i),
  .divisor_i   (divisor_i),
  .state_i     (state),
  .done_i      (done_o),
  .div_zero_i  (div_zero_o),
  .quotient_i  (quotient_o),
  .remainder_i (remainder_o)
);

// File: tb/test_restoring_divider.sv
`timescale 1ns/1ps
module test_restoring_divider;
  localparam int W = 4;
  localparam int LAT = 2 * W;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] dividend_i = '0;
  logic [W-1:0] divisor_i = '0;
  logic [W-1:0] quotient_o, remainder_o;
  logic         done_o, div_zero_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  restoring_divider #(.WIDTH(W)) i_restoring_divider (
    .clk_i, .rst_ni, .start_i, .dividend_i, .divisor_i,
    .quotient_o, .remainder_o, .done_o, .div_zero_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive a start on one falling edge, drop it on the next (start sampled in between).
  task automatic launch(input int dvd, input int dvs);
    @(negedge clk_i);
    dividend_i = W'(dvd);
    divisor_i  = W'(dvs);
    start_i    = 1'b1;
    @(negedge clk_i);
    start_i    = 1'b0;
  endtask

  // Count falling edges until done, starting at the falling edge after the start edge.
  task automatic wait_done(output int n);
    n = 0;
    while (!done_o && n < 40) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  task automatic run_one(input int dvd, input int dvs);
    int n;
    launch(dvd, dvs);
    wait_done(n);
    check(n == LAT, "R4 latency", n, LAT);
    check(int'(quotient_o) == dvd / dvs, "R2 quotient", quotient_o, dvd / dvs);
    check(int'(remainder_o) == dvd % dvs, "R3 remainder", remainder_o, dvd % dvs);
    check(div_zero_o == 1'b0, "R6 flag low", div_zero_o, 0);
    @(negedge clk_i);
    check(done_o == 1'b0, "R4 single pulse", done_o, 0);
  endtask

  task automatic t_reset();
    check(quotient_o == '0 && remainder_o == '0, "R1 reset data", {quotient_o, remainder_o}, 0);
    check(done_o == 1'b0 && div_zero_o == 1'b0, "R1 reset flags", {done_o, div_zero_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(quotient_o == '0 && remainder_o == '0, "R1 after release", {quotient_o, remainder_o}, 0);
    check(done_o == 1'b0, "R1 no done", done_o, 0);
  endtask

  task automatic t_directed();
    run_one(7, 3);
    run_one(15, 1);
    run_one(15, 15);
    run_one(3, 7);
    run_one(0, 5);
    run_one(14, 4);
  endtask

  task automatic t_exhaustive();
    for (int a = 0; a < (1 << W); a++)
      for (int b = 1; b < (1 << W); b++)
        run_one(a, b);
  endtask

  task automatic t_zero_divisor();
    launch(11, 0);
    check(done_o == 1'b1, "R5 immediate done", done_o, 1);
    check(div_zero_o == 1'b1, "R5 flag", div_zero_o, 1);
    check(quotient_o == '1, "R5 quotient", quotient_o, (1 << W) - 1);
    check(int'(remainder_o) == 11, "R5 remainder", remainder_o, 11);
    @(negedge clk_i);
    check(done_o == 1'b0, "R5 single pulse", done_o, 0);
    repeat (5) @(negedge clk_i);
    check(div_zero_o == 1'b1, "R6 flag held", div_zero_o, 1);
    check(quotient_o == '1, "R8 held after zero", quotient_o, (1 << W) - 1);
    launch(9, 2);
    check(div_zero_o == 1'b0, "R6 flag cleared", div_zero_o, 0);
    begin
      int n;
      wait_done(n);
      check(n == LAT - 0, "R4 latency after zero", n, LAT);
      check(int'(quotient_o) == 4 && int'(remainder_o) == 1, "R2 after zero", quotient_o, 4);
    end
    @(negedge clk_i);
  endtask

  task automatic t_busy_start();
    int n;
    launch(13, 3);
    n = 0;
    while (!done_o && n < 40) begin
      if (n == 3) begin
        dividend_i = W'(2);
        divisor_i  = W'(1);
        start_i    = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
      n++;
    end
    start_i = 1'b0;
    check(n == LAT, "R7 latency kept", n, LAT);
    check(int'(quotient_o) == 4, "R7 quotient kept", quotient_o, 4);
    check(int'(remainder_o) == 1, "R7 remainder kept", remainder_o, 1);
    // start during the done cycle is also ignored
    dividend_i = W'(15);
    divisor_i  = W'(0);
    start_i    = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(done_o == 1'b0, "R7 no new done", done_o, 0);
    n = 0;
    for (int k = 0; k < LAT + 4; k++) begin
      @(negedge clk_i);
      if (done_o) n++;
    end
    check(n == 0, "R7 no launch from done cycle", n, 0);
    check(div_zero_o == 1'b0, "R7 flag untouched", div_zero_o, 0);
    check(int'(quotient_o) == 4 && int'(remainder_o) == 1, "R8 result held", quotient_o, 4);
  endtask

  task automatic t_hold_idle();
    run_one(12, 5);
    dividend_i = W'(1);
    divisor_i  = W'(1);
    repeat (6) @(negedge clk_i);
    check(int'(quotient_o) == 2, "R8 quotient held", quotient_o, 2);
    check(int'(remainder_o) == 2, "R8 remainder held", remainder_o, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_directed();
    t_zero_divisor();
    t_busy_start();
    t_hold_idle();
    t_exhaustive();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule